// File: doc/BRIEF.md
# Multi-Mode DMA Channel Controller

This block moves blocks of bytes between I/O devices and memory for a processor. It has a small set of channels, and each channel has its own hardware request line and acknowledge line. Software programs each channel with a start address, a unit count and a control word, then sets the enable bit. An enabled channel that sees its request line high competes for service. The engine first takes the system bus from the CPU through a request/grant handshake. It then moves each byte as two single-cycle strobes: a read into a one-byte holding register, and a write from that register.

Each channel chooses how it shares the bus. In block mode it keeps the bus for the whole block. In byte-steal mode it gives the bus back after every byte. In background mode it never requests the bus and moves data only in cycles where the CPU reports the bus unused. A block ends when the count steps down past zero. At that point the controller emits a one-cycle terminal pulse, sets a sticky completion flag that drives the interrupt, and then does one of two things. It either reloads the channel from its base values and keeps it enabled, or it clears the channel's enable bit.

Top module: `dmac_top`

## Requirements
- R1: A channel whose enable bit (control bit 0) is clear never starts a transfer, whatever its request line does. Its current address and count stay unchanged.
- R2: A programmed count of N moves N+1 bytes. The current address goes up by one after each byte, and the count goes down by one. Without reload, a count read back after completion returns all ones in the count width (0x00FF for an 8-bit count).
- R3: `tc` is high for exactly one clock: the clock of the final write strobe of the block.
- R4: In block and byte-steal modes, no read or write strobe is driven unless both `br` and `bg` are high. The engine raises `br` and waits for `bg` before its first strobe.
- R5: Block mode (control bits 4:3 = 00) keeps `br` high from the first byte to the last byte of the block, so `br` rises once per block.
- R6: Byte-steal mode (control bits 4:3 = 01) drops `br` after every byte and raises it again for the next byte, so `br` rises once per byte.
- R7: Background mode (control bits 4:3 = 10) never raises `br`, and it drives strobes only in clocks where `cpu_idle` is high.
- R8: With auto-reload set (control bit 1), completion restores the current address and count from the base values and leaves the channel enabled. With auto-reload clear, completion clears the enable bit.
- R9: Control bit 2 set means memory to I/O: `mem_rd` is followed by `io_wr` carrying the byte read. Control bit 2 clear means I/O to memory: `io_rd` is followed by `mem_wr`. At most one strobe is active in any clock.
- R10: Completion sets the channel's flag in status bits [NCH-1:0], and `irq` is the OR of these flags. Writing a 1 to a flag bit of the status field (field 3) clears that flag.
- R11: When several enabled channels request at the same time, the lowest-numbered channel is serviced first.
- R12: Register fields are: 0 = address (writing sets base and current, reading returns current), 1 = count (same scheme), 2 = control {mode[4:3], dir[2], reload[1], enable[0]}, 3 = status {busy[2NCH-1:NCH], flag[NCH-1:0]}. Read data appears one clock after `reg_ch`/`reg_fld` are presented. After reset, every field reads zero and `br`, `tc` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_ch | input | $clog2(NCH) | Channel selected for register access |
| reg_fld | input | 2 | Field selected for register access |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Registered read data |
| dreq | input | NCH | Per-channel hardware request |
| dack | output | NCH | One-hot channel acknowledge during a strobe |
| br | output | 1 | Bus request to the CPU |
| bg | input | 1 | Bus grant from the CPU |
| cpu_idle | input | 1 | CPU is not using the bus this clock |
| mem_addr | output | AW | Memory address of the active channel |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the read clock |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| io_wdata | output | DW | I/O write data |
| io_rdata | input | DW | I/O read data, valid in the read clock |
| tc | output | 1 | Terminal-count pulse |
| irq | output | 1 | Completion interrupt |

## Verification
The bench runs the transfer engine with four distinct patterns.

- A four-byte block from memory to I/O with an immediate grant separates block bus ownership (a single request rise) from the other modes. It also exposes off-by-one count handling through the number of bytes moved and the final address and count.
- A three-byte I/O-to-memory transfer in byte-steal mode separates per-byte release (three request rises) and checks the data path in the other direction.
- A background transfer, run while the CPU idle line toggles, separates bus-free movement from strobes taken during busy clocks.
- Two simultaneous single-byte requests separate the priority order, and a reloading channel separates the two completion outcomes.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam logic [1:0] MODE_BLOCK = 2'd0;
  localparam logic [1:0] MODE_STEAL = 2'd1;
  localparam logic [1:0] MODE_BGND  = 2'd2;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_CTL  = 2'd2;
  localparam logic [1:0] FLD_STAT = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RD, S_WR} eng_state_e;
endpackage

// File: rtl/dmac_arb.sv
module dmac_arb #(
  parameter int N = 4
) (
  input  logic [N-1:0]         req,
  output logic [$clog2(N)-1:0] win,
  output logic                 any
);
  localparam int IW = $clog2(N);

  always_comb begin
    any = |req;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) win = IW'(i);
    end
  end
endmodule

// File: rtl/dmac_chan.sv
module dmac_chan #(
  parameter int AW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_addr,
  input  logic          wr_cnt,
  input  logic          wr_ctl,
  input  logic          clr_flag,
  input  logic [AW-1:0] wdata,
  input  logic          step,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_cnt,
  output logic          en,
  output logic          reload,
  output logic          dir,
  output logic [1:0]    mode,
  output logic          flag,
  output logic          last
);
  logic [AW-1:0] base_addr;
  logic [CW-1:0] base_cnt;

  assign last = (cur_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
      en        <= 1'b0;
      reload    <= 1'b0;
      dir       <= 1'b0;
      mode      <= 2'd0;
      flag      <= 1'b0;
    end else begin
      if (wr_addr) begin
        base_addr <= wdata;
        cur_addr  <= wdata;
      end
      if (wr_cnt) begin
        base_cnt <= wdata[CW-1:0];
        cur_cnt  <= wdata[CW-1:0];
      end
      if (wr_ctl) begin
        en     <= wdata[0];
        reload <= wdata[1];
        dir    <= wdata[2];
        mode   <= wdata[4:3];
      end
      if (clr_flag) flag <= 1'b0;
      if (step) begin
        if (last) begin
          flag <= 1'b1;
          if (reload) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
          end else begin
            cur_addr <= cur_addr + 1'b1;
            cur_cnt  <= cur_cnt - 1'b1;
            en       <= 1'b0;
          end
        end else begin
          cur_addr <= cur_addr + 1'b1;
          cur_cnt  <= cur_cnt - 1'b1;
        end
      end
    end
  end

  AST_STEP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    step |-> en); // R1
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (step && !last && !wr_addr && !wr_cnt) |=>
      (cur_addr == AW'($past(cur_addr) + 1'b1)) && (cur_cnt == CW'($past(cur_cnt) - 1'b1))); // R2
  AST_RELOAD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (step && last && reload && !wr_cnt && !wr_ctl) |=> (en && cur_cnt == $past(base_cnt))); // R8
  AST_END_DISABLES: assert property (@(posedge clk) disable iff (rst)
    (step && last && !reload && !wr_ctl) |=> !en); // R8
endmodule

// File: rtl/dmac_top.sv
module dmac_top
  import dmac_pkg::*;
#(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int CW  = 8,
  parameter int DW  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   reg_we,
  input  logic [$clog2(NCH)-1:0] reg_ch,
  input  logic [1:0]             reg_fld,
  input  logic [AW-1:0]          reg_wdata,
  output logic [AW-1:0]          reg_rdata,
  input  logic [NCH-1:0]         dreq,
  output logic [NCH-1:0]         dack,
  output logic                   br,
  input  logic                   bg,
  input  logic                   cpu_idle,
  output logic [AW-1:0]          mem_addr,
  output logic                   mem_rd,
  output logic                   mem_wr,
  output logic [DW-1:0]          mem_wdata,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   io_rd,
  output logic                   io_wr,
  output logic [DW-1:0]          io_wdata,
  input  logic [DW-1:0]          io_rdata,
  output logic                   tc,
  output logic                   irq
);
  localparam int CHW = $clog2(NCH);

  logic [AW-1:0]  ch_addr [NCH];
  logic [CW-1:0]  ch_cnt  [NCH];
  logic [1:0]     ch_mode [NCH];
  logic [NCH-1:0] ch_en, ch_reload, ch_dir, ch_flag, ch_last, step_v, busy;

  eng_state_e     st;
  logic [CHW-1:0] ach;
  logic [DW-1:0]  hold;
  logic [CHW-1:0] win;
  logic           any_req;
  logic [NCH-1:0] live_req;
  logic           is_bg, is_steal, go, rd_cyc, wr_cyc;

  assign live_req = dreq & ch_en;

  dmac_arb #(.N(NCH)) u_arb (.req(live_req), .win(win), .any(any_req));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan #(.AW(AW), .CW(CW)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_addr  (reg_we && reg_ch == CHW'(g) && reg_fld == FLD_ADDR),
      .wr_cnt   (reg_we && reg_ch == CHW'(g) && reg_fld == FLD_CNT),
      .wr_ctl   (reg_we && reg_ch == CHW'(g) && reg_fld == FLD_CTL),
      .clr_flag (reg_we && reg_fld == FLD_STAT && reg_wdata[g]),
      .wdata    (reg_wdata),
      .step     (step_v[g]),
      .cur_addr (ch_addr[g]),
      .cur_cnt  (ch_cnt[g]),
      .en       (ch_en[g]),
      .reload   (ch_reload[g]),
      .dir      (ch_dir[g]),
      .mode     (ch_mode[g]),
      .flag     (ch_flag[g]),
      .last     (ch_last[g])
    );
    assign busy[g] = (st != S_IDLE) && (ach == CHW'(g));
  end

  assign is_bg    = (ch_mode[ach] == MODE_BGND);
  assign is_steal = (ch_mode[ach] == MODE_STEAL);
  assign go       = is_bg ? cpu_idle : 1'b1;
  assign rd_cyc   = (st == S_RD) && go;
  assign wr_cyc   = (st == S_WR) && go;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      ach  <= '0;
      hold <= '0;
    end else begin
      case (st)
        S_IDLE: if (any_req) begin
          ach <= win;
          st  <= (ch_mode[win] == MODE_BGND) ? S_RD : S_REQ;
        end
        S_REQ: if (bg) st <= S_RD;
        S_RD: if (go) begin
          hold <= ch_dir[ach] ? mem_rdata : io_rdata;
          st   <= S_WR;
        end
        S_WR: if (go) begin
          st <= (ch_last[ach] || is_steal || is_bg) ? S_IDLE : S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign br        = (st != S_IDLE) && !is_bg;
  assign mem_rd    = rd_cyc && ch_dir[ach];
  assign io_rd     = rd_cyc && !ch_dir[ach];
  assign io_wr     = wr_cyc && ch_dir[ach];
  assign mem_wr    = wr_cyc && !ch_dir[ach];
  assign mem_addr  = ch_addr[ach];
  assign mem_wdata = hold;
  assign io_wdata  = hold;
  assign dack      = (rd_cyc || wr_cyc) ? (NCH'(1) << ach) : '0;
  assign step_v    = wr_cyc ? (NCH'(1) << ach) : '0;
  assign tc        = wr_cyc && ch_last[ach];
  assign irq       = |ch_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_fld)
        FLD_ADDR: reg_rdata <= ch_addr[reg_ch];
        FLD_CNT:  reg_rdata <= AW'(ch_cnt[reg_ch]);
        FLD_CTL:  reg_rdata <= AW'({ch_mode[reg_ch], ch_dir[reg_ch], ch_reload[reg_ch], ch_en[reg_ch]});
        default:  reg_rdata <= AW'({busy, ch_flag});
      endcase
    end
  end

  logic [NCH-1:0] below_ach;
  logic           any_strobe;
  assign below_ach  = (NCH'(1) << ach) - NCH'(1);
  assign any_strobe = mem_rd || mem_wr || io_rd || io_wr;

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && !(|live_req)) |=> st == S_IDLE); // R1
  AST_TC_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    tc |=> !tc); // R3
  AST_GRANT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && !is_bg) |-> (br && bg)); // R4
  AST_BLOCK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && !is_bg && !is_steal && !ch_last[ach]) |=> br); // R5
  AST_STEAL_RELEASES: assert property (@(posedge clk) disable iff (rst)
    (wr_cyc && is_steal) |=> !br); // R6
  AST_BGND_QUIET: assert property (@(posedge clk) disable iff (rst)
    (any_strobe && is_bg) |-> (cpu_idle && !br)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1); // R9
  AST_FLAG_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
    tc |=> irq); // R10
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && |live_req) |=> (($past(live_req) & below_ach) == '0)); // R11
endmodule

// File: tb/dmac_top_tb.sv
module dmac_top_tb;
  localparam int NCH = 4, AW = 16, CW = 8, DW = 8;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [1:0] reg_ch = '0, reg_fld = '0;
  logic [AW-1:0] reg_wdata = '0, reg_rdata;
  logic [NCH-1:0] dreq = '0, dack;
  logic br, bg = 1'b0, cpu_idle = 1'b0;
  logic [AW-1:0] mem_addr;
  logic mem_rd, mem_wr, io_rd, io_wr, tc, irq;
  logic [DW-1:0] mem_wdata, mem_rdata, io_wdata, io_rdata;

  logic [7:0] mem [256];
  logic [7:0] io_src = 8'hC0;
  logic idle_toggle = 1'b0;
  int checks = 0, fails = 0;
  int n_memrd, n_memwr, n_iord, n_iowr, n_tc, n_br_rise, n_busy_strobe, first_dack;
  logic [7:0] iow_log [8];
  logic br_prev = 1'b0;

  always #10 clk = ~clk;

  dmac_top #(.NCH(NCH), .AW(AW), .CW(CW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_ch(reg_ch), .reg_fld(reg_fld),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .br(br), .bg(bg), .cpu_idle(cpu_idle), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata), .tc(tc), .irq(irq));

  assign mem_rdata = mem[mem_addr[7:0]];
  assign io_rdata  = io_src;

  always @(posedge clk) begin
    bg <= br;
    if (idle_toggle) cpu_idle <= ~cpu_idle;
    if (mem_wr) mem[mem_addr[7:0]] <= mem_wdata;
    if (io_rd) io_src <= io_src + 8'd1;
    if (mem_rd) n_memrd++;
    if (mem_wr) n_memwr++;
    if (io_rd) n_iord++;
    if (io_wr) begin
      if (n_iowr < 8) iow_log[n_iowr] = io_wdata;
      n_iowr++;
    end
    if (tc) n_tc++;
    if (br && !br_prev) n_br_rise++;
    br_prev = br;
    if ((mem_rd || mem_wr || io_rd || io_wr) && !cpu_idle) n_busy_strobe++;
    if (|dack && first_dack < 0) begin
      for (int i = 0; i < NCH; i++) if (dack[i]) first_dack = i;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    n_memrd = 0; n_memwr = 0; n_iord = 0; n_iowr = 0; n_tc = 0;
    n_br_rise = 0; n_busy_strobe = 0; first_dack = -1;
  endtask

  task automatic wr(int ch, int fld, int data);
    @(negedge clk);
    reg_we = 1'b1; reg_ch = 2'(ch); reg_fld = 2'(fld); reg_wdata = AW'(data);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(int ch, int fld, output int val);
    @(negedge clk);
    reg_ch = 2'(ch); reg_fld = 2'(fld);
    @(negedge clk);
    val = int'(reg_rdata);
  endtask

  task automatic run_until_tc(int ch);
    int n = 0;
    @(negedge clk);
    dreq[ch] = 1'b1;
    while (!tc && n < 400) begin
      @(negedge clk);
      n++;
    end
    dreq[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    chk("R12 br after reset", int'(br), 0);
    chk("R12 irq after reset", int'(irq), 0);
    chk("R12 tc after reset", int'(tc), 0);
    rd(2, 3, v); chk("R12 status after reset", v, 0);
    rd(1, 1, v); chk("R12 count after reset", v, 0);
    rd(3, 2, v); chk("R12 control after reset", v, 0);
  endtask

  task automatic t_disabled();
    int v;
    clr_mon();
    wr(0, 0, 'h10); wr(0, 1, 3); wr(0, 2, 'h04);
    @(negedge clk); dreq[0] = 1'b1;
    repeat (20) @(negedge clk);
    dreq[0] = 1'b0;
    chk("R1 no bus request while disabled", n_br_rise, 0);
    chk("R1 no transfer while disabled", n_iowr + n_memrd, 0);
    rd(0, 1, v); chk("R1 count untouched", v, 3);
    rd(0, 0, v); chk("R1 address untouched", v, 'h10);
  endtask

  task automatic t_block();
    int v;
    for (int i = 0; i < 4; i++) mem[8'h10 + i] = 8'(8'h50 + i);
    clr_mon();
    wr(0, 2, 'h05);
    run_until_tc(0);
    chk("R2 four bytes for count 3", n_iowr, 4);
    chk("R9 memory reads in mem-to-io", n_memrd, 4);
    for (int i = 0; i < 4; i++) chk("R9 byte carried to io", int'(iow_log[i]), 'h50 + i);
    chk("R3 one terminal pulse", n_tc, 1);
    chk("R5 single bus request for block", n_br_rise, 1);
    rd(0, 0, v); chk("R2 final address", v, 'h14);
    rd(0, 1, v); chk("R2 count underflowed", v, 'hFF);
    rd(0, 2, v); chk("R8 enable cleared without reload", v, 'h04);
    rd(0, 3, v); chk("R10 status flag ch0", v, 'h1);
    chk("R10 irq raised", int'(irq), 1);
    wr(0, 3, 'h1);
    rd(0, 3, v); chk("R10 flag cleared by write", v, 0);
    chk("R10 irq dropped", int'(irq), 0);
  endtask

  task automatic t_steal();
    int v;
    for (int i = 0; i < 3; i++) mem[8'h40 + i] = 8'h00;
    @(negedge clk); io_src = 8'hC0;
    clr_mon();
    wr(1, 0, 'h40); wr(1, 1, 2); wr(1, 2, 'h09);
    run_until_tc(1);
    chk("R6 bus requested per byte", n_br_rise, 3);
    chk("R9 io reads in io-to-mem", n_iord, 3);
    for (int i = 0; i < 3; i++) chk("R9 byte stored to memory", int'(mem[8'h40 + i]), 'hC0 + i);
    chk("R3 one terminal pulse steal", n_tc, 1);
    rd(1, 3, v); chk("R10 status flag ch1", v, 'h2);
    wr(0, 3, 'h2);
  endtask

  task automatic t_bgnd();
    int v;
    mem[8'h20] = 8'h11; mem[8'h21] = 8'h22;
    clr_mon();
    wr(2, 0, 'h20); wr(2, 1, 1); wr(2, 2, 'h15);
    @(negedge clk); idle_toggle = 1'b1;
    run_until_tc(2);
    idle_toggle = 1'b0;
    chk("R7 no bus request in background", n_br_rise, 0);
    chk("R7 no strobe while cpu busy", n_busy_strobe, 0);
    chk("R7 bytes moved", n_iowr, 2);
    chk("R7 first byte", int'(iow_log[0]), 'h11);
    chk("R7 second byte", int'(iow_log[1]), 'h22);
    wr(0, 3, 'h4);
  endtask

  task automatic t_reload();
    int v;
    mem[8'h30] = 8'h33; mem[8'h31] = 8'h34;
    clr_mon();
    wr(3, 0, 'h30); wr(3, 1, 1); wr(3, 2, 'h07);
    run_until_tc(3);
    chk("R8 bytes moved before reload", n_iowr, 2);
    rd(3, 2, v); chk("R8 channel stays enabled", v, 'h07);
    rd(3, 1, v); chk("R8 count reloaded", v, 1);
    rd(3, 0, v); chk("R8 address reloaded", v, 'h30);
    wr(3, 2, 'h0);
    wr(0, 3, 'h8);
  endtask

  task automatic t_priority();
    int v, n;
    mem[8'h60] = 8'hA1; mem[8'h61] = 8'hA0;
    clr_mon();
    wr(1, 0, 'h60); wr(1, 1, 0); wr(1, 2, 'h0D);
    wr(0, 0, 'h61); wr(0, 1, 0); wr(0, 2, 'h0D);
    @(negedge clk); dreq[1:0] = 2'b11;
    n = 0; v = 0;
    while ((v & 3) != 3 && n < 100) begin
      rd(0, 3, v);
      n++;
    end
    dreq[1:0] = 2'b00;
    repeat (3) @(negedge clk);
    chk("R11 lowest channel served first", first_dack, 0);
    chk("R11 first byte from ch0", int'(iow_log[0]), 'hA0);
    chk("R11 both served", n_iowr, 2);
    wr(0, 3, 'h3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    clr_mon();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_block();
    t_steal();
    t_bgnd();
    t_reload();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule